// File: doc/BRIEF.md
# Algebraic Doubleword Shift-Immediate Execute Unit

This unit executes one integer instruction of a 64-bit processor: an arithmetic right shift of a doubleword by a count carried in the instruction word itself. A 32-bit instruction word and the 64-bit source operand enter together under a valid strobe. One clock later the unit presents the shifted value, the destination register index, the carry bit and an optional 4-bit condition field, each with its own write enable.

The shift count is six bits wide and is split across two fields of the word that are not next to each other. The carry reports that a negative operand lost at least one set bit off the low end, which lets a following add-to-zero-with-carry round a signed division by a power of two toward zero. When the word's record bit is set, the unit also forms a signed compare of the result against zero and copies the incoming summary-overflow flag into the field. Words that are not this instruction are flagged as unrecognised and write nothing.

Top module: `ashr_imm_unit`

## Requirements
- R1: With bit 0 as the most significant bit of the word, the word is recognised only when bits 0–5 equal 31 and the 9-bit field in bits 21–29 equals 413 (word pattern 0x7C000674 with all operand fields zero); any other word drives `op_known` low.
- R2: `dst_idx` carries bits 11–15 of the accepted word.
- R3: The shift count is bit 30 as its high bit followed by bits 16–20 as its five low bits (0 to 63), and `result` is the source shifted right by that count with the sign bit copied into every vacated upper position.
- R4: `ca_out` is 1 exactly when the source is negative and at least one 1 bit is shifted out of the low end; otherwise it is 0.
- R5: A count of zero passes the source to `result` unchanged and gives `ca_out` = 0.
- R6: `cr_we` is 1 only for a valid recognised word whose bit 31 (record bit) is 1.
- R7: `cr_field` is {LT, GT, EQ, SO} from bit 3 down to bit 0: a signed 64-bit compare of `result` with zero, exactly one of LT/GT/EQ set, and bit 0 a copy of `so_in` sampled with the word.
- R8: `ca_we` is 1 for every valid recognised word; for an unrecognised word both `ca_we` and `cr_we` stay 0.
- R9: Outputs appear one clock after the word is accepted: `out_valid` follows `in_valid` by one cycle, and synchronous reset clears `out_valid`, `ca_we` and `cr_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand are present |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| so_in | input | 1 | Summary-overflow flag at issue |
| out_valid | output | 1 | Output stage holds a result |
| op_known | output | 1 | Output-stage word was recognised |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Shifted value |
| ca_out | output | 1 | Carry bit |
| ca_we | output | 1 | Carry write enable |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we | output | 1 | Condition field write enable |

## Verification
The carry and the condition field are both produced in the same output cycle from the same word, so a negative source that loses set bits with the record bit on must raise the carry and the LT bit together, while the summary-overflow copy rides along in the field. The bench provokes this with record-form words on negative operands that do and do not lose ones, and with positive operands and zero results, and judges carry, both enables and all four field bits against values it derives bit by bit from the requirements in the one cycle where they appear.

// File: rtl/ashr_pkg.sv
package ashr_pkg;

    localparam int XLEN      = 64;
    localparam int CNT_W     = 6;
    localparam int IDX_W     = 5;
    localparam int IWORD_W   = 32;
    localparam int PRIM_W    = 6;
    localparam int EXT_W     = 9;
    localparam int CRF_W     = 4;

    localparam logic [PRIM_W-1:0] PRIM_CODE = 6'd31;
    localparam logic [EXT_W-1:0]  EXT_CODE  = 9'd413;

    typedef struct packed {
        logic             match;
        logic [IDX_W-1:0] src_idx;
        logic [IDX_W-1:0] dst_idx;
        logic [CNT_W-1:0] count;
        logic             rec;
    } dec_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    // ones in the positions that a right shift by cnt discards
    function automatic logic [XLEN-1:0] lost_mask(input logic [CNT_W-1:0] cnt);
        logic [XLEN-1:0] one;
        one = {{(XLEN-1){1'b0}}, 1'b1};
        return (one << cnt) - one;
    endfunction

endpackage

// File: rtl/ashr_decode.sv
module ashr_decode
    import ashr_pkg::*;
(
    input  logic [IWORD_W-1:0] word,
    output dec_t               dec
);
    // big-endian bit numbering: field bit n sits at word[IWORD_W-1-n]
    logic [PRIM_W-1:0] prim;
    logic [EXT_W-1:0]  ext;

    always_comb begin
        prim          = word[31:26];
        ext           = word[10:2];
        dec.match     = (prim == PRIM_CODE) && (ext == EXT_CODE);
        dec.src_idx   = word[25:21];
        dec.dst_idx   = word[20:16];
        dec.count     = {word[1], word[15:11]};
        dec.rec       = word[0];
    end
endmodule

// File: rtl/ashr_shift.sv
module ashr_shift
    import ashr_pkg::*;
(
    input  logic [XLEN-1:0]  src,
    input  logic [CNT_W-1:0] count,
    output logic [XLEN-1:0]  shifted,
    output logic             carry
);
    logic [XLEN-1:0] lost;

    always_comb begin
        shifted = $signed(src) >>> count;
        lost    = src & lost_mask(count);
        carry   = src[XLEN-1] & (|lost);
    end
endmodule

// File: rtl/ashr_cond.sv
module ashr_cond
    import ashr_pkg::*;
(
    input  logic [XLEN-1:0] value,
    input  logic            so,
    output crf_t            crf
);
    always_comb begin
        crf.lt = value[XLEN-1];
        crf.eq = (value == '0);
        crf.gt = !value[XLEN-1] && (value != '0);
        crf.so = so;
    end
endmodule

// File: rtl/ashr_imm_unit.sv
module ashr_imm_unit
    import ashr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [63:0]         src_val,
    input  logic                so_in,
    output logic                out_valid,
    output logic                op_known,
    output logic [4:0]          dst_idx,
    output logic [63:0]         result,
    output logic                ca_out,
    output logic                ca_we,
    output logic [3:0]          cr_field,
    output logic                cr_we
);
    dec_t            dec;
    logic [XLEN-1:0] sh_val;
    logic            sh_ca;
    crf_t            crf;

    ashr_decode u_dec (.word(instr), .dec(dec));

    ashr_shift u_sh (
        .src     (src_val),
        .count   (dec.count),
        .shifted (sh_val),
        .carry   (sh_ca)
    );

    ashr_cond u_cond (.value(sh_val), .so(so_in), .crf(crf));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            op_known  <= 1'b0;
            dst_idx   <= '0;
            result    <= '0;
            ca_out    <= 1'b0;
            ca_we     <= 1'b0;
            cr_field  <= '0;
            cr_we     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ca_we     <= in_valid && dec.match;
            cr_we     <= in_valid && dec.match && dec.rec;
            if (in_valid) begin
                op_known <= dec.match;
                dst_idx  <= dec.dst_idx;
                result   <= sh_val;
                ca_out   <= sh_ca;
                cr_field <= crf;
            end
        end
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !ca_we && !cr_we);

    // R8
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !op_known) |-> (!ca_we && !cr_we));

    // R6
    rec_needs_ca_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ca_we);

    // R4
    carry_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (ca_we && ca_out) |-> result[63]);

    // R5
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[1] == 1'b0 && instr[15:11] == 5'd0)
            |=> (result == $past(src_val)) && !ca_out);

    // R7
    one_relation_chk: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> $countones(cr_field[3:1]) == 1);

endmodule

// File: tb/ashr_imm_unit_test.sv
module ashr_imm_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_val;
    logic        so_in;
    logic        out_valid, op_known, ca_out, ca_we, cr_we;
    logic [4:0]  dst_idx;
    logic [63:0] result;
    logic [3:0]  cr_field;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ashr_imm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .so_in(so_in), .out_valid(out_valid),
        .op_known(op_known), .dst_idx(dst_idx), .result(result),
        .ca_out(ca_out), .ca_we(ca_we), .cr_field(cr_field), .cr_we(cr_we)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] ra,
                                       input logic [5:0] cnt, input logic rc);
        logic [31:0] w;
        w = 32'h7C00_0674;
        w[25:21] = rs;
        w[20:16] = ra;
        w[15:11] = cnt[4:0];
        w[1]     = cnt[5];
        w[0]     = rc;
        return w;
    endfunction

    // R3/R4/R7 expected values, derived bit by bit
    task automatic run_op(input string tag, input logic [31:0] w,
                          input logic [63:0] s, input logic so);
        logic [5:0]  cnt;
        logic [63:0] exp_res;
        logic        exp_ca, known, lt, eq;
        cnt   = {w[1], w[15:11]};
        known = (w[31:26] == 6'd31) && (w[10:2] == 9'd413);
        for (int i = 0; i < 64; i++)
            exp_res[i] = (i + int'(cnt) < 64) ? s[i + int'(cnt)] : s[63];
        exp_ca = 1'b0;
        for (int i = 0; i < 64; i++)
            if (i < int'(cnt) && s[i] && s[63]) exp_ca = 1'b1;
        lt = exp_res[63];
        eq = (exp_res == 64'd0);
        @(negedge clk);
        in_valid = 1'b1; instr = w; src_val = s; so_in = so;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9"}, "out_valid", 64'(out_valid), 64'd1);
        check({tag, " R1"}, "op_known", 64'(op_known), 64'(known));
        check({tag, " R8"}, "ca_we", 64'(ca_we), 64'(known));
        check({tag, " R6"}, "cr_we", 64'(cr_we), 64'(known && w[0]));
        if (known) begin
            check({tag, " R2"}, "dst_idx", 64'(dst_idx), 64'(w[20:16]));
            check({tag, " R3"}, "result", result, exp_res);
            check({tag, " R4"}, "ca_out", 64'(ca_out), 64'(exp_ca));
            if (w[0])
                check({tag, " R7"}, "cr_field", 64'(cr_field),
                      64'({lt, !lt && !eq, eq, so}));
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b1; instr = mk(5'd1, 5'd2, 6'd3, 1'b1);
        src_val = 64'hFFFF_FFFF_FFFF_FFFF; so_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "reset out_valid", 64'(out_valid), 64'd0);
        check("R9", "reset ca_we", 64'(ca_we), 64'd0);
        check("R9", "reset cr_we", 64'(cr_we), 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "idle out_valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_count_zero;
        // R5: pass-through and carry cleared even with a negative odd source
        run_op("zero", mk(5'd3, 5'd7, 6'd0, 1'b1), 64'hFFFF_0000_0000_0001, 1'b0);
        check("R5", "zero pass", result, 64'hFFFF_0000_0000_0001);
        check("R5", "zero carry", 64'(ca_out), 64'd0);
        run_op("zero_pos", mk(5'd3, 5'd8, 6'd0, 1'b0), 64'h0123_4567_89AB_CDEF, 1'b0);
    endtask

    task automatic t_count_edges;
        run_op("one_neg_odd", mk(5'd1, 5'd9, 6'd1, 1'b1), 64'h8000_0000_0000_0003, 1'b1);
        check("R4", "cnt1 neg odd carry", 64'(ca_out), 64'd1);
        run_op("one_neg_even", mk(5'd1, 5'd9, 6'd1, 1'b0), 64'h8000_0000_0000_0002, 1'b0);
        check("R4", "cnt1 neg even carry", 64'(ca_out), 64'd0);
        run_op("max_neg", mk(5'd2, 5'd10, 6'd63, 1'b1), 64'h8000_0000_0000_0000, 1'b0);
        check("R3", "cnt63 neg", result, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("max_pos", mk(5'd2, 5'd11, 6'd63, 1'b1), 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
        check("R7", "cnt63 pos EQ|SO", 64'(cr_field), 64'b0011);
        run_op("high_bit", mk(5'd4, 5'd12, 6'd32, 1'b0), 64'hF000_0000_8000_0000, 1'b0);
        check("R3", "cnt32 split field", result, 64'hFFFF_FFFF_F000_0000);
    endtask

    task automatic t_sign_mix;
        run_op("pos_loss", mk(5'd5, 5'd13, 6'd4, 1'b1), 64'h0000_0000_0000_00FF, 1'b0);
        check("R4", "positive loses ones", 64'(ca_out), 64'd0);
        run_op("neg_noloss", mk(5'd5, 5'd14, 6'd8, 1'b1), 64'hFFFF_FFFF_FFFF_FF00, 1'b0);
        check("R4", "negative no loss", 64'(ca_out), 64'd0);
        run_op("neg_loss_same_cycle", mk(5'd5, 5'd15, 6'd8, 1'b1), 64'hFFFF_FFFF_FFFF_FF80, 1'b1);
        check("R4", "negative loss", 64'(ca_out), 64'd1);
        check("R7", "LT with SO", 64'(cr_field), 64'b1001);
    endtask

    task automatic t_unknown;
        logic [31:0] w;
        w = mk(5'd1, 5'd1, 6'd2, 1'b1); w[31:26] = 6'd30;
        run_op("bad_prim", w, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        w = mk(5'd1, 5'd1, 6'd2, 1'b1); w[10:2] = 9'd412;
        run_op("bad_ext", w, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check("R8", "bad ext cr_we", 64'(cr_we), 64'd0);
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            logic [63:0] s;
            logic [5:0]  c;
            s = {$urandom, $urandom};
            c = 6'($urandom);
            run_op("rand", mk(5'($urandom), 5'($urandom), c, 1'($urandom)), s, 1'($urandom));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_count_zero();
        t_count_edges();
        t_sign_mix();
        t_unknown();
        t_random();
        @(negedge clk);
        check("R9", "drain out_valid", 64'(out_valid), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule